// File: doc/BRIEF.md
# Sideband Mailbox Request Sequencer

This block takes one sideband message request at a time and carries it through a mailbox that sits behind a small register bus. The request names a destination port, a register offset, an opcode, a posted flag, byte enables, a BAR selector, a function number and write data. The sequencer then acts as the bus master and works through a fixed list of steps:

- it reads the mailbox function's identity word;
- it waits until the mailbox is idle;
- it loads the address, extended-address, command, route and data registers;
- it sets the busy bit and waits for it to clear;
- it fetches the read data when the opcode calls for it.

When the request ends, the block gives one result. The result holds a pass/fail flag, a separate timeout flag, a two-bit completion code and the read data. It appears with a single-cycle done pulse.

Each bus access is a request that is held until the slave acknowledges it. A bit in the request selects a 32-bit access or a 16-bit access, and 16-bit data travels in bits 15:0. The mailbox register offsets are part of the behaviour:

| Register | Offset |
|---|---|
| Identity | 0x00 |
| Address | 0xD0 |
| Data | 0xD4 |
| Status/command | 0xD8 |
| Route | 0xDA |
| Extended address | 0xDC |

In the status/command register:

- Bit 0 is the busy bit.
- Bits 2:1 hold the completion code.
- Bit 7 holds the posted flag.
- Bits 15:8 hold the opcode.

Top module: `sbmsg_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` then stays low until the result. Every request ends with `res_done` high for exactly one cycle.
- R2: Only opcodes 0, 1, 4, 5, 6, 7 and 13 are supported. Any other opcode ends the request with ok=0, timeout=0 and resp=1, and the block issues no bus transaction at all.
- R3: The first bus transaction is a 16-bit read of offset 0x00. If it returns 0xFFFF, the request ends with ok=0, timeout=0 and resp=1, and no further bus transaction follows.
- R4: Before it writes any register, the block reads the 16-bit status at 0xD8 again and again until bit 0 reads 0.
- R5: The block then makes 32-bit writes. It writes (port ID << 24) | offset to 0xD0, and then writes offset >> 16 to 0xDC.
- R6: Next it reads 0xD8 and writes back a 16-bit value. That value keeps bits 6:0 of the word it read, carries the opcode in bits 15:8 and the posted flag in bit 7.
- R7: The block writes a 16-bit route word to 0xDA:
  - byte enables[3:0] go in bits 15:12;
  - bit 11 is 0;
  - BAR[2:0] goes in bits 10:8;
  - function ID[7:0] goes in bits 7:0.
- R8: The block makes a 32-bit write to 0xD4. The value is the request data for opcodes 1, 5 and 7, and zero for every other opcode.
- R9: The block reads 0xD8 once more and writes back the same value with bit 0 set. It then polls 0xD8 until bit 0 reads 0. The six writes always come in this order: 0xD0, 0xDC, 0xD8, 0xDA, 0xD4, 0xD8.
- R10: After the final poll, resp equals bits 2:1 of the last status word read. ok is 1 exactly when that code is 0.
- R11: On success with opcode 0, 4 or 6, the block makes one 32-bit read of 0xD4 and returns that value on `res_rdata`. In every other case it does not read 0xD4 and `res_rdata` is 0.
- R12: In each polling phase, a cycle counter starts again from zero. The phase times out if a poll returns busy after the counter has reached TIMEOUT_CYC. A timeout ends the request with ok=0, timeout=1 and resp=1, and no further bus transaction follows.
- R13: While `bus_req` is high and `bus_ack` is low, the bus request and all of its fields stay unchanged.
- R14: After reset:
  - `req_ready` is 1;
  - `res_done` is 0;
  - `bus_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_pid | input | 8 | Destination port ID |
| req_offset | input | 32 | Register offset |
| req_opcode | input | 8 | Message opcode |
| req_posted | input | 1 | Posted message flag |
| req_be | input | 4 | Byte enables |
| req_bar | input | 3 | BAR selector |
| req_fid | input | 8 | Function ID |
| req_wdata | input | 32 | Write data |
| res_done | output | 1 | One-cycle result pulse |
| res_ok | output | 1 | Request completed successfully |
| res_timeout | output | 1 | A busy poll timed out |
| res_resp | output | 2 | Completion code |
| res_rdata | output | 32 | Read data |
| bus_req | output | 1 | Bus transaction request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wide | output | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | output | 8 | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction acknowledge |
| bus_rdata | input | 32 | Read data, valid with acknowledge |

## Verification
The bench concentrates on the corner cases below. For each one, it describes what a faulty design would do.

- **Unsupported opcodes and a hidden function.** A design that let a bad opcode or an all-ones identity word through would touch the mailbox. The bench catches this through the bus transaction count.
- **A mailbox that stays busy for a while before and after the trigger.** A design that skipped the first poll would write while the mailbox was still busy. A design that skipped the second poll would report a stale completion code.
- **Timeouts in each of the two polling phases.** A design that did not restart its counter, or that kept going after a timeout, would show writes that should not happen or the wrong flags.
- **Non-zero completion codes and write-type opcodes.** A design that read the data register anyway, or returned data for a write-type opcode, would show a non-zero `res_rdata` or an extra data read.

// File: rtl/sbmsg_pkg.sv
package sbmsg_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = 16;

  localparam logic [ADDR_W-1:0] REG_IDENT = 8'h00;
  localparam logic [ADDR_W-1:0] REG_ADDR  = 8'hD0;
  localparam logic [ADDR_W-1:0] REG_DATA  = 8'hD4;
  localparam logic [ADDR_W-1:0] REG_STAT  = 8'hD8;
  localparam logic [ADDR_W-1:0] REG_ROUTE = 8'hDA;
  localparam logic [ADDR_W-1:0] REG_EXT   = 8'hDC;

  localparam logic [1:0] CODE_NOSUP = 2'd1;

  localparam logic [7:0] OP_MRD  = 8'd0;
  localparam logic [7:0] OP_MWR  = 8'd1;
  localparam logic [7:0] OP_CRD  = 8'd4;
  localparam logic [7:0] OP_CWR  = 8'd5;
  localparam logic [7:0] OP_PRD  = 8'd6;
  localparam logic [7:0] OP_PWR  = 8'd7;
  localparam logic [7:0] OP_LOCK = 8'd13;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_IDENT, S_POLL_PRE, S_W_ADDR, S_W_EXT, S_R_STAT,
    S_W_STAT, S_W_ROUTE, S_W_DATA, S_R_TRIG, S_W_TRIG, S_POLL_POST, S_R_DATA
  } seq_state_e;
endpackage

// File: rtl/sbmsg_opdec.sv
module sbmsg_opdec
  import sbmsg_pkg::*;
(
  input  logic [7:0] opcode,
  output logic       legal,
  output logic       wr_type,
  output logic       rd_type
);
  always_comb begin
    legal   = 1'b0;
    wr_type = 1'b0;
    rd_type = 1'b0;
    case (opcode)
      OP_MRD, OP_CRD, OP_PRD: begin legal = 1'b1; rd_type = 1'b1; end
      OP_MWR, OP_CWR, OP_PWR: begin legal = 1'b1; wr_type = 1'b1; end
      OP_LOCK:                legal = 1'b1;
      default:                legal = 1'b0;
    endcase
  end

  // R8: a write-type opcode is never also read-type
  always_comb begin
    p_rw_excl_r8: assert (!(wr_type && rd_type)) else $error("opcode both read and write type");
  end
endmodule

// File: rtl/sbmsg_polltimer.sv
module sbmsg_polltimer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart || (cnt_q != LIM);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LIM);

  p_restart_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  p_sat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !restart |=> expired);
endmodule

// File: rtl/sbmsg_busport.sv
module sbmsg_busport
  import sbmsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              op_we,
  input  logic              op_wide,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_wide,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  output logic              cmp
);
  logic req_q, issue, retire;

  assign issue  = go && !req_q;
  assign retire = req_q && bus_ack;
  assign cmp    = retire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (retire) req_q <= 1'b0;
    else if (issue)  req_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_we    <= 1'b0;
      bus_wide  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (issue) begin
      bus_we    <= op_we;
      bus_wide  <= op_wide;
      bus_addr  <= op_addr;
      bus_wdata <= op_wdata;
    end
  end

  assign bus_req = req_q;

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata)
                            && $stable(bus_we) && $stable(bus_wide));
endmodule

// File: rtl/sbmsg_seq.sv
module sbmsg_seq
  import sbmsg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_pid,
  input  logic [31:0] req_offset,
  input  logic [7:0]  req_opcode,
  input  logic        req_posted,
  input  logic [3:0]  req_be,
  input  logic [2:0]  req_bar,
  input  logic [7:0]  req_fid,
  input  logic [31:0] req_wdata,
  output logic        res_done,
  output logic        res_ok,
  output logic        res_timeout,
  output logic [1:0]  res_resp,
  output logic [31:0] res_rdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic        bus_wide,
  output logic [7:0]  bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);
  seq_state_e state_q, state_d;

  logic [7:0]  pid_q, op_q, fid_q;
  logic [31:0] off_q, wd_q;
  logic        posted_q;
  logic [3:0]  be_q;
  logic [2:0]  bar_q;
  logic [HALF_W-1:0] stat_q;

  logic legal, wr_type, rd_type;
  logic cmp, expired;

  logic              go, op_we, op_wide;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic accept, restart, stat_ld, fin, fin_ok, fin_to, fin_rd;
  logic [1:0] fin_code;

  sbmsg_opdec u_dec (
    .opcode (op_q),
    .legal  (legal),
    .wr_type(wr_type),
    .rd_type(rd_type)
  );

  sbmsg_polltimer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .expired(expired)
  );

  sbmsg_busport u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .op_we    (op_we),
    .op_wide  (op_wide),
    .op_addr  (op_addr),
    .op_wdata (op_wdata),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_wide (bus_wide),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ack  (bus_ack),
    .cmp      (cmp)
  );

  // next-state and bus command
  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    restart  = 1'b0;
    stat_ld  = 1'b0;
    fin      = 1'b0;
    fin_ok   = 1'b0;
    fin_to   = 1'b0;
    fin_rd   = 1'b0;
    fin_code = CODE_NOSUP;
    go       = 1'b0;
    op_we    = 1'b0;
    op_wide  = 1'b0;
    op_addr  = REG_STAT;
    op_wdata = '0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = S_CHECK;
        end
      end
      S_CHECK: begin
        if (!legal) fin = 1'b1;
        else        state_d = S_IDENT;
      end
      S_IDENT: begin
        go      = 1'b1;
        op_addr = REG_IDENT;
        if (cmp) begin
          if (bus_rdata[HALF_W-1:0] == '1) fin = 1'b1;
          else begin
            state_d = S_POLL_PRE;
            restart = 1'b1;
          end
        end
      end
      S_POLL_PRE: begin
        go = 1'b1;
        if (cmp) begin
          if (!bus_rdata[0]) state_d = S_W_ADDR;
          else if (expired) begin
            fin    = 1'b1;
            fin_to = 1'b1;
          end
        end
      end
      S_W_ADDR: begin
        go       = 1'b1;
        op_we    = 1'b1;
        op_wide  = 1'b1;
        op_addr  = REG_ADDR;
        op_wdata = {pid_q, 24'd0} | off_q;
        if (cmp) state_d = S_W_EXT;
      end
      S_W_EXT: begin
        go       = 1'b1;
        op_we    = 1'b1;
        op_wide  = 1'b1;
        op_addr  = REG_EXT;
        op_wdata = {16'd0, off_q[31:16]};
        if (cmp) state_d = S_R_STAT;
      end
      S_R_STAT: begin
        go = 1'b1;
        if (cmp) begin
          stat_ld = 1'b1;
          state_d = S_W_STAT;
        end
      end
      S_W_STAT: begin
        go       = 1'b1;
        op_we    = 1'b1;
        op_wdata = {16'd0, op_q, posted_q, stat_q[6:0]};
        if (cmp) state_d = S_W_ROUTE;
      end
      S_W_ROUTE: begin
        go       = 1'b1;
        op_we    = 1'b1;
        op_addr  = REG_ROUTE;
        op_wdata = {16'd0, be_q, 1'b0, bar_q, fid_q};
        if (cmp) state_d = S_W_DATA;
      end
      S_W_DATA: begin
        go       = 1'b1;
        op_we    = 1'b1;
        op_wide  = 1'b1;
        op_addr  = REG_DATA;
        op_wdata = wr_type ? wd_q : '0;
        if (cmp) state_d = S_R_TRIG;
      end
      S_R_TRIG: begin
        go = 1'b1;
        if (cmp) begin
          stat_ld = 1'b1;
          state_d = S_W_TRIG;
        end
      end
      S_W_TRIG: begin
        go       = 1'b1;
        op_we    = 1'b1;
        op_wdata = {16'd0, stat_q[15:1], 1'b1};
        if (cmp) begin
          state_d = S_POLL_POST;
          restart = 1'b1;
        end
      end
      S_POLL_POST: begin
        go = 1'b1;
        if (cmp) begin
          if (!bus_rdata[0]) begin
            if (bus_rdata[2:1] != 2'd0) begin
              fin      = 1'b1;
              fin_code = bus_rdata[2:1];
            end else if (rd_type) begin
              state_d = S_R_DATA;
            end else begin
              fin      = 1'b1;
              fin_ok   = 1'b1;
              fin_code = 2'd0;
            end
          end else if (expired) begin
            fin    = 1'b1;
            fin_to = 1'b1;
          end
        end
      end
      S_R_DATA: begin
        go      = 1'b1;
        op_wide = 1'b1;
        op_addr = REG_DATA;
        if (cmp) begin
          fin      = 1'b1;
          fin_ok   = 1'b1;
          fin_rd   = 1'b1;
          fin_code = 2'd0;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_q    <= '0;
      off_q    <= '0;
      op_q     <= '0;
      posted_q <= 1'b0;
      be_q     <= '0;
      bar_q    <= '0;
      fid_q    <= '0;
      wd_q     <= '0;
    end else if (accept) begin
      pid_q    <= req_pid;
      off_q    <= req_offset;
      op_q     <= req_opcode;
      posted_q <= req_posted;
      be_q     <= req_be;
      bar_q    <= req_bar;
      fid_q    <= req_fid;
      wd_q     <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_ld) stat_q <= bus_rdata[HALF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_ok      <= 1'b0;
      res_timeout <= 1'b0;
      res_resp    <= 2'd0;
      res_rdata   <= '0;
    end else if (fin) begin
      res_ok      <= fin_ok;
      res_timeout <= fin_to;
      res_resp    <= fin_code;
      res_rdata   <= fin_rd ? bus_rdata : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_done <= 1'b0;
    else        res_done <= fin;
  end

  assign req_ready = (state_q == S_IDLE);

  p_accept_locks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);
  p_badop_nobus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CHECK) && !legal |=> res_done && !bus_req);
  p_ok_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_done && res_ok |-> (res_resp == 2'd0) && !res_timeout);
  p_timeout_fail_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_done && res_timeout |-> !res_ok && (res_resp == CODE_NOSUP));
  p_nodata_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_done && !res_ok |-> (res_rdata == '0));
endmodule

// File: tb/sbmsg_seq_tb_top.sv
module sbmsg_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TO_CYC     = 64;
  localparam logic [19:0] STUCK = 20'hFFFFF;

  logic clk, rst_n;
  logic req_valid, req_ready, req_posted;
  logic [7:0] req_pid, req_opcode, req_fid;
  logic [31:0] req_offset, req_wdata;
  logic [3:0] req_be;
  logic [2:0] req_bar;
  logic res_done, res_ok, res_timeout;
  logic [1:0] res_resp;
  logic [31:0] res_rdata;
  logic bus_req, bus_we, bus_wide, bus_ack;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int n_chk, n_bad;

  sbmsg_seq #(.TIMEOUT_CYC(TO_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pid(req_pid),
    .req_offset(req_offset), .req_opcode(req_opcode), .req_posted(req_posted),
    .req_be(req_be), .req_bar(req_bar), .req_fid(req_fid), .req_wdata(req_wdata),
    .res_done(res_done), .res_ok(res_ok), .res_timeout(res_timeout),
    .res_resp(res_resp), .res_rdata(res_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // mailbox model configuration (written by the test only)
  logic        cfg_load;
  logic [15:0] cfg_id, cfg_stat;
  logic [19:0] cfg_pre, cfg_post;
  logic [1:0]  cfg_code;
  logic [31:0] cfg_rdval;

  // mailbox model state (written by the model only)
  logic [15:0] m_stat;
  logic [31:0] m_data;
  logic [19:0] m_cnt;
  logic        m_armed, m_early_wr;
  logic [1:0]  m_lat;
  int          m_wcnt, m_tx, m_drd;
  logic [7:0]  wlog_a [0:15];
  logic [31:0] wlog_d [0:15];

  always @(posedge clk) begin
    if (cfg_load) begin
      m_stat     <= {cfg_stat[15:1], (cfg_pre != 0)};
      m_cnt      <= cfg_pre;
      m_armed    <= 1'b0;
      m_early_wr <= 1'b0;
      m_data     <= 32'h0;
      m_wcnt     <= 0;
      m_tx       <= 0;
      m_drd      <= 0;
      bus_ack    <= 1'b0;
      m_lat      <= 2'd0;
    end else begin
      if (m_stat[0]) begin
        if (m_cnt != 0) m_cnt <= m_cnt - 1'b1;
        else begin
          m_stat[0] <= 1'b0;
          if (m_armed) begin
            m_stat[2:1] <= cfg_code;
            m_data      <= cfg_rdval;
          end
        end
      end
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        if (m_lat != 0) m_lat <= m_lat - 1'b1;
        else begin
          bus_ack <= 1'b1;
          m_lat   <= 2'($urandom_range(0, 2));
          m_tx    <= m_tx + 1;
          if (bus_we) begin
            if (m_stat[0] && !m_armed) m_early_wr <= 1'b1;
            if (m_wcnt < 16) begin
              wlog_a[m_wcnt] <= bus_addr;
              wlog_d[m_wcnt] <= bus_wdata;
            end
            m_wcnt <= m_wcnt + 1;
            if (bus_addr == 8'hD8) begin
              m_stat <= bus_wdata[15:0];
              if (bus_wdata[0]) begin
                m_armed <= 1'b1;
                m_cnt   <= cfg_post;
              end
            end else if (bus_addr == 8'hD4) begin
              m_data <= bus_wdata;
            end
          end else begin
            case (bus_addr)
              8'h00:   bus_rdata <= {16'h0, cfg_id};
              8'hD8:   bus_rdata <= {16'h0, m_stat};
              8'hD4: begin bus_rdata <= m_data; m_drd <= m_drd + 1; end
              default: bus_rdata <= 32'hDEAD_BEEF;
            endcase
          end
        end
      end
    end
  end

  function automatic bit is_legal(logic [7:0] op);
    return op inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7, 8'd13};
  endfunction
  function automatic bit is_wr(logic [7:0] op);
    return op inside {8'd1, 8'd5, 8'd7};
  endfunction
  function automatic bit is_rd(logic [7:0] op);
    return op inside {8'd0, 8'd4, 8'd6};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(logic [7:0] op, logic posted, logic [7:0] pid, logic [31:0] off,
                         logic [3:0] be, logic [2:0] bar, logic [7:0] fid, logic [31:0] wd,
                         logic [15:0] id, logic [15:0] st, logic [19:0] pre,
                         logic [19:0] post, logic [1:0] code, logic [31:0] rdval);
    logic [31:0] e_w [0:5];
    logic [7:0]  e_a [0:5];
    logic [31:0] stw;
    int guard;
    bit exp_ok, exp_to, exp_rd;
    logic [1:0] exp_resp;
    int exp_w;
    @(negedge clk);
    cfg_id = id; cfg_stat = {st[15:1], 1'b0}; cfg_pre = pre; cfg_post = post;
    cfg_code = code; cfg_rdval = rdval; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    req_opcode = op; req_posted = posted; req_pid = pid; req_offset = off;
    req_be = be; req_bar = bar; req_fid = fid; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 ready low after accept", {31'd0, req_ready}, 32'd0);
    guard = 0;
    while (!res_done && guard < 3000) begin @(negedge clk); guard++; end
    chk("R1 done seen", {31'd0, res_done}, 32'd1);
    @(negedge clk);
    chk("R1 done single cycle", {31'd0, res_done}, 32'd0);

    stw = {16'd0, op, posted, st[6:1], 1'b0};
    e_a[0] = 8'hD0; e_w[0] = {pid, 24'd0} | off;
    e_a[1] = 8'hDC; e_w[1] = {16'd0, off[31:16]};
    e_a[2] = 8'hD8; e_w[2] = stw;
    e_a[3] = 8'hDA; e_w[3] = {16'd0, be, 1'b0, bar, fid};
    e_a[4] = 8'hD4; e_w[4] = is_wr(op) ? wd : 32'd0;
    e_a[5] = 8'hD8; e_w[5] = stw | 32'd1;

    exp_to = 0; exp_resp = 2'd1; exp_ok = 0; exp_rd = 0; exp_w = 6;
    if (!is_legal(op)) begin
      exp_w = 0;
      chk("R2 no bus traffic on bad opcode", m_tx, 0);
    end else if (id == 16'hFFFF) begin
      exp_w = 0;
      chk("R3 only identity read when hidden", m_tx, 1);
    end else if (pre == STUCK) begin
      exp_w = 0; exp_to = 1;
    end else if (post == STUCK) begin
      exp_to = 1;
    end else begin
      exp_resp = code;
      exp_ok   = (code == 2'd0);
      exp_rd   = exp_ok && is_rd(op);
    end
    chk("R12 timeout flag", {31'd0, res_timeout}, {31'd0, exp_to});
    chk("R10 ok flag", {31'd0, res_ok}, {31'd0, exp_ok});
    chk("R10 response code", {30'd0, res_resp}, {30'd0, exp_resp});
    chk("R11 read data", res_rdata, exp_rd ? rdval : 32'd0);
    chk("R11 data register reads", m_drd, exp_rd ? 1 : 0);
    chk("R4 no write while mailbox busy", {31'd0, m_early_wr}, 32'd0);
    chk("R9 write count", m_wcnt, exp_w);
    for (int i = 0; i < exp_w; i++) begin
      chk($sformatf("R9 write %0d offset", i), {24'd0, wlog_a[i]}, {24'd0, e_a[i]});
      case (i)
        0, 1:    chk("R5 address words", wlog_d[i], e_w[i]);
        2:       chk("R6 command word", wlog_d[i], e_w[i]);
        3:       chk("R7 route word", wlog_d[i], e_w[i]);
        4:       chk("R8 data word", wlog_d[i], e_w[i]);
        default: chk("R9 trigger word", wlog_d[i], e_w[i]);
      endcase
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] ops [0:6];
    logic [7:0] op;
    void'($urandom(32'h5EED_1234));
    ops[0] = 8'd0; ops[1] = 8'd1; ops[2] = 8'd4; ops[3] = 8'd5;
    ops[4] = 8'd6; ops[5] = 8'd7; ops[6] = 8'd13;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; req_valid = 1'b0; cfg_load = 1'b1;
    cfg_id = 16'h1234; cfg_stat = 16'h0; cfg_pre = 0; cfg_post = 0;
    cfg_code = 0; cfg_rdval = 0;
    req_opcode = 0; req_posted = 0; req_pid = 0; req_offset = 0;
    req_be = 0; req_bar = 0; req_fid = 0; req_wdata = 0;
    bus_rdata = 32'h0;
    repeat (3) @(negedge clk);
    chk("R14 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R14 done after reset", {31'd0, res_done}, 32'd0);
    chk("R14 bus idle after reset", {31'd0, bus_req}, 32'd0);
    rst_n = 1'b1;
    cfg_load = 1'b0;
    @(negedge clk);

    // directed corner cases
    run_one(8'd2,   0, 8'hA1, 32'h0000_0010, 4'hF, 3'd0, 8'h00, 32'h1, 16'h1234, 16'h0, 0, 0, 0, 0);
    run_one(8'd255, 1, 8'hA1, 32'h0000_0010, 4'hF, 3'd0, 8'h00, 32'h1, 16'h1234, 16'h0, 0, 0, 0, 0);
    run_one(8'd6,   0, 8'h6E, 32'h0000_0400, 4'hF, 3'd0, 8'h00, 32'h0, 16'hFFFF, 16'h0, 0, 0, 0, 0);
    run_one(8'd6,   0, 8'h6E, 32'h0002_0400, 4'h3, 3'd5, 8'h3C, 32'h0, 16'h8086, 16'h0006, 7, 3, 0, 32'hCAFE_F00D);
    run_one(8'd7,   1, 8'hC0, 32'h0001_FFFC, 4'hC, 3'd7, 8'hFF, 32'h1357_9BDF, 16'h8086, 16'h007E, 0, 0, 0, 32'h5555_AAAA);
    run_one(8'd0,   0, 8'h10, 32'h0000_0020, 4'hF, 3'd1, 8'h01, 32'h0, 16'h8086, 16'h0000, 2, 4, 2'd2, 32'h1111_2222);
    run_one(8'd4,   0, 8'h11, 32'h0000_0030, 4'hF, 3'd2, 8'h02, 32'h0, 16'h8086, 16'h0000, 0, 0, 2'd3, 32'h3333_4444);
    run_one(8'd5,   0, 8'h12, 32'h0000_0040, 4'h1, 3'd3, 8'h03, 32'h7777_8888, 16'h8086, 16'h0000, STUCK, 0, 0, 0);
    run_one(8'd1,   1, 8'h13, 32'h0000_0050, 4'h2, 3'd4, 8'h04, 32'h9999_AAAA, 16'h8086, 16'h0000, 0, STUCK, 0, 0);
    run_one(8'd13,  0, 8'h14, 32'hFFFF_FFFF, 4'hF, 3'd6, 8'h80, 32'hFFFF_0000, 16'h8086, 16'hFFFE, 1, 1, 0, 32'hABCD_0123);
    run_one(8'd0,   0, 8'h15, 32'h0000_0060, 4'hF, 3'd0, 8'h05, 32'h0, 16'h8086, 16'h0000, 0, 0, 0, 32'h0BAD_F00D);

    // random stimulus
    for (int k = 0; k < 150; k++) begin
      if ($urandom_range(0, 9) == 0) op = 8'($urandom_range(0, 255));
      else op = ops[$urandom_range(0, 6)];
      run_one(op, 1'($urandom), 8'($urandom), $urandom, 4'($urandom), 3'($urandom),
              8'($urandom), $urandom,
              ($urandom_range(0, 19) == 0) ? 16'hFFFF : 16'($urandom_range(0, 16'hFFFE)),
              16'($urandom), 20'($urandom_range(0, 12)), 20'($urandom_range(0, 25)),
              ($urandom_range(0, 1) == 1) ? 2'd0 : 2'($urandom), $urandom);
    end
    finish_run();
  end
endmodule